// File: doc/BRIEF.md
# Two-level aperture address translator

This block maps bus addresses that land in a graphics aperture onto physical page addresses. Translation has two levels. The first level is a directory of 64 slots held on chip. Each slot names a 1 MiB-aligned table page in system memory. That table page holds 1024 word-sized second-level entries. Host software fills the directory by writing packed words to one configuration register. The block reads second-level entries through a single-word memory read port, one read at a time.

A lookup starts with the aperture check. An address outside the configured window is passed through unchanged, and the response flags it as a miss. An address inside the window is looked up next in a small fully associative translation cache. If the cache misses, the block checks the directory slot. It then reads the second-level entry from memory, unless the slot is absent. Absent slots and invalid entries give a fault. Two events empty the cache: a rising enable bit in the control register, and any write to the directory.

Top module: `aperture_xlate`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_req_valid is 0. Every directory slot is absent, so a lookup inside the aperture faults with no memory read.
- R2: A configuration write to offset 0xB8 loads one directory slot. Bits 5:0 select the slot, bit 8 is the present flag and bits 31:20 give the table page. Bits 11:9 and 7:6 are ignored. A load with bit 8 clear makes the slot absent.
- R3: The slot used for a lookup is (addr[31:22] − base[31:22]) taken modulo 1024. The memory read address is {table page, 8'h00, addr[21:12], 2'b00}.
- R4: During a walk, mem_req_valid stays high and mem_addr stays constant until mem_rsp_valid is seen. The response follows one cycle later. If entry bit 0 is 1, then rsp_paddr = {entry[31:12], addr[11:0]} and both fault and miss are 0.
- R5: A second-level entry with bit 0 clear gives rsp_fault=1 and rsp_paddr=0. Such a fault is never cached, so repeating the lookup reads memory again.
- R6: A lookup that hits an absent slot responds one cycle after acceptance with rsp_fault=1. It makes no memory read.
- R7: The size register at offset 0xB4 takes a code in bits 5:0. Codes 0, 32, 48 and 56 allow 64, 32, 16 and 8 slots. A lookup whose slot value is at or above that count responds one cycle after acceptance with rsp_miss=1 and rsp_paddr = the request address, and makes no memory read.
- R8: A lookup to a page already translated successfully responds one cycle after acceptance with no memory read. Its address is the cached page joined to the new page offset.
- R9: The cache holds 4 pages and replaces them round robin. After a flush, the fifth distinct page stored evicts the first one, and the other three stay cached.
- R10: The control register is at offset 0xB0, and its bit 7 resets to 0. A write that sets bit 7 while the stored bit 7 is 0 flushes the cache. Any other control write does not flush the cache.
- R11: Any write to the directory register flushes the whole cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| ap_base | input | 32 | Aperture base bus address |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Bus address to translate |
| req_ready | output | 1 | Block can accept a lookup |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 32 | Translated or passed-through address |
| rsp_fault | output | 1 | Absent slot or invalid entry |
| rsp_miss | output | 1 | Address outside the aperture |
| mem_req_valid | output | 1 | Second-level read pending |
| mem_addr | output | 32 | Second-level entry address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Second-level entry read |

## Verification
The bench builds the block with its default parameters: 64 directory slots, 1024 entries per table and a 4-entry cache. With these values the bench can reach slot 63 and the boundary at 64. It can also run the shrinking windows of every size code, and can evict an entry after five distinct pages. The memory model answers two cycles after each request, so the bench can observe the read request held stable while the read is pending. It counts memory reads to tell cache hits, absent-slot faults and pass-through misses apart from real walks.

// File: rtl/ax_pkg.sv
`timescale 1ns/1ps
package ax_pkg;
    localparam int ADDR_W    = 32;
    localparam int CFG_AW    = 8;
    localparam int PG_SH     = 12;
    localparam int TPG_LSB   = 20;
    localparam int TPG_W     = ADDR_W - TPG_LSB;
    localparam int PRES_BIT  = 8;
    localparam int FLUSH_BIT = 7;

    localparam logic [CFG_AW-1:0] OFF_CTRL = 8'hB0;
    localparam logic [CFG_AW-1:0] OFF_SIZE = 8'hB4;
    localparam logic [CFG_AW-1:0] OFF_DIR  = 8'hB8;

    typedef enum logic {ST_IDLE, ST_WALK} walk_st_e;
endpackage

// File: rtl/ax_cfg.sv
`timescale 1ns/1ps
module ax_cfg
    import ax_pkg::*;
#(
    parameter int DIR_SLOTS = 64,
    localparam int DIR_W = $clog2(DIR_SLOTS),
    localparam int LIM_W = DIR_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    output logic                dir_we,
    output logic [DIR_W-1:0]    dir_slot,
    output logic [TPG_W-1:0]    dir_page,
    output logic                dir_present,
    output logic [LIM_W-1:0]    slot_lim,
    output logic                tlb_flush
);
    typedef struct packed {
        logic [5:0] size_code;
        logic       ctl_en;
    } cfg_s;

    cfg_s cfg_d, cfg_q;
    logic wr_ctrl, wr_size, set_en;
    logic unused_cfg;

    assign unused_cfg = ^{cfg_wdata[TPG_LSB-1:PRES_BIT+1], cfg_wdata[6]};

    always_comb begin
        cfg_d    = cfg_q;
        wr_ctrl  = cfg_wr_en && (cfg_addr == OFF_CTRL);
        wr_size  = cfg_wr_en && (cfg_addr == OFF_SIZE);
        dir_we   = cfg_wr_en && (cfg_addr == OFF_DIR);
        set_en   = wr_ctrl && cfg_wdata[FLUSH_BIT] && !cfg_q.ctl_en;
        if (wr_ctrl) cfg_d.ctl_en = cfg_wdata[FLUSH_BIT];
        if (wr_size) cfg_d.size_code = cfg_wdata[5:0];
        dir_slot    = cfg_wdata[DIR_W-1:0];
        dir_page    = cfg_wdata[ADDR_W-1:TPG_LSB];
        dir_present = cfg_wdata[PRES_BIT];
        tlb_flush   = dir_we || set_en;
        slot_lim    = LIM_W'(DIR_SLOTS) >> $countones(cfg_q.size_code[5:3]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // a second enabling write in a row never flushes
    AST_CTRL_NO_REFLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr == OFF_CTRL && cfg_wdata[FLUSH_BIT] &&
         $past(cfg_wr_en && cfg_addr == OFF_CTRL && cfg_wdata[FLUSH_BIT]))
        |-> !tlb_flush); // R10

    AST_DIR_WRITE_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr == OFF_DIR) |-> tlb_flush); // R11
endmodule

// File: rtl/ax_dir.sv
`timescale 1ns/1ps
module ax_dir
    import ax_pkg::*;
#(
    parameter int DIR_SLOTS = 64,
    localparam int DIR_W = $clog2(DIR_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DIR_W-1:0]  wr_slot,
    input  logic [TPG_W-1:0]  wr_page,
    input  logic              wr_present,
    input  logic [DIR_W-1:0]  rd_slot,
    output logic              rd_present,
    output logic [TPG_W-1:0]  rd_page
);
    typedef struct packed {
        logic [DIR_SLOTS-1:0]            present;
        logic [DIR_SLOTS-1:0][TPG_W-1:0] page;
    } dir_s;

    dir_s dir_d, dir_q;

    always_comb begin
        dir_d = dir_q;
        if (we) begin
            dir_d.present[wr_slot] = wr_present;
            dir_d.page[wr_slot]    = wr_page;
        end
        rd_present = dir_q.present[rd_slot];
        rd_page    = dir_q.page[rd_slot];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dir_q <= '0;
        else        dir_q <= dir_d;
    end

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (dir_q.present[$past(wr_slot)] == $past(wr_present))); // R2
endmodule

// File: rtl/ax_tlb.sv
`timescale 1ns/1ps
module ax_tlb #(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 16,
    parameter int PPN_W   = 20,
    localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             hit,
    output logic [PPN_W-1:0] hit_ppn,
    input  logic             ins_en,
    input  logic [TAG_W-1:0] ins_tag,
    input  logic [PPN_W-1:0] ins_ppn
);
    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][TAG_W-1:0] tag;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
        logic [PTR_W-1:0]              ptr;
    } tlb_s;

    tlb_s tlb_d, tlb_q;
    logic [ENTRIES-1:0] hit_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = tlb_q.valid[g] && (tlb_q.tag[g] == lk_tag);
    end

    always_comb begin
        tlb_d   = tlb_q;
        hit     = |hit_vec;
        hit_ppn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_ppn = hit_ppn | tlb_q.ppn[i];
        end
        if (flush) begin
            tlb_d.valid = '0;
            tlb_d.ptr   = '0;
        end else if (ins_en) begin
            tlb_d.valid[tlb_q.ptr] = 1'b1;
            tlb_d.tag[tlb_q.ptr]   = ins_tag;
            tlb_d.ppn[tlb_q.ptr]   = ins_ppn;
            tlb_d.ptr = (tlb_q.ptr == PTR_W'(ENTRIES - 1)) ? '0 : tlb_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tlb_q <= '0;
        else        tlb_q <= tlb_d;
    end

    AST_TLB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R9

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tlb_q.valid == '0)); // R10

    AST_INSERT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && !flush) |=> tlb_q.valid[$past(tlb_q.ptr)]); // R9
endmodule

// File: rtl/aperture_xlate.sv
`timescale 1ns/1ps
module aperture_xlate
    import ax_pkg::*;
#(
    parameter int DIR_SLOTS   = 64,
    parameter int L2_ENTRIES  = 1024,
    parameter int TLB_ENTRIES = 4,
    localparam int DIR_W  = $clog2(DIR_SLOTS),
    localparam int OFF_W  = $clog2(L2_ENTRIES),
    localparam int DIR_SH = PG_SH + OFF_W,
    localparam int HI_W   = ADDR_W - DIR_SH,
    localparam int TAG_W  = DIR_W + OFF_W,
    localparam int PPN_W  = ADDR_W - PG_SH,
    localparam int LIM_W  = DIR_W + 1,
    localparam int PAD_W  = TPG_LSB - OFF_W - 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    input  logic [ADDR_W-1:0]   ap_base,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                req_ready,
    output logic                rsp_valid,
    output logic [ADDR_W-1:0]   rsp_paddr,
    output logic                rsp_fault,
    output logic                rsp_miss,
    output logic                mem_req_valid,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_rsp_valid,
    input  logic [ADDR_W-1:0]   mem_rsp_data
);
    typedef struct packed {
        walk_st_e           st;
        logic               rsp_v;
        logic [ADDR_W-1:0]  paddr;
        logic               fault;
        logic               miss;
        logic               mreq;
        logic [ADDR_W-1:0]  maddr;
        logic [TAG_W-1:0]   tag;
        logic [PG_SH-1:0]   lo;
    } xl_s;

    xl_s xl_d, xl_q;

    logic               dir_we, dir_present, tlb_flush;
    logic [DIR_W-1:0]   dir_slot;
    logic [TPG_W-1:0]   dir_page;
    logic [LIM_W-1:0]   slot_lim;
    logic [HI_W-1:0]    hi_diff;
    logic               in_ap;
    logic [DIR_W-1:0]   lk_slot;
    logic [OFF_W-1:0]   lk_off;
    logic [TAG_W-1:0]   lk_tag;
    logic               rd_present;
    logic [TPG_W-1:0]   rd_page;
    logic               tlb_hit, ins_en;
    logic [PPN_W-1:0]   tlb_ppn;
    logic               unused_top;

    assign unused_top = ^{ap_base[DIR_SH-1:0], mem_rsp_data[PG_SH-1:1]};

    ax_cfg #(.DIR_SLOTS(DIR_SLOTS)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .dir_we     (dir_we),
        .dir_slot   (dir_slot),
        .dir_page   (dir_page),
        .dir_present(dir_present),
        .slot_lim   (slot_lim),
        .tlb_flush  (tlb_flush)
    );

    ax_dir #(.DIR_SLOTS(DIR_SLOTS)) u_dir (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (dir_we),
        .wr_slot    (dir_slot),
        .wr_page    (dir_page),
        .wr_present (dir_present),
        .rd_slot    (lk_slot),
        .rd_present (rd_present),
        .rd_page    (rd_page)
    );

    ax_tlb #(.ENTRIES(TLB_ENTRIES), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_tlb (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (tlb_flush),
        .lk_tag  (lk_tag),
        .hit     (tlb_hit),
        .hit_ppn (tlb_ppn),
        .ins_en  (ins_en),
        .ins_tag (xl_q.tag),
        .ins_ppn (mem_rsp_data[ADDR_W-1:PG_SH])
    );

    always_comb begin
        hi_diff = req_addr[ADDR_W-1:DIR_SH] - ap_base[ADDR_W-1:DIR_SH];
        in_ap   = hi_diff < HI_W'(slot_lim);
        lk_slot = hi_diff[DIR_W-1:0];
        lk_off  = req_addr[DIR_SH-1:PG_SH];
        lk_tag  = {lk_slot, lk_off};
        ins_en  = 1'b0;

        xl_d       = xl_q;
        xl_d.rsp_v = 1'b0;

        unique case (xl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!in_ap) begin
                        xl_d.rsp_v = 1'b1;
                        xl_d.paddr = req_addr;
                        xl_d.fault = 1'b0;
                        xl_d.miss  = 1'b1;
                    end else if (tlb_hit) begin
                        xl_d.rsp_v = 1'b1;
                        xl_d.paddr = {tlb_ppn, req_addr[PG_SH-1:0]};
                        xl_d.fault = 1'b0;
                        xl_d.miss  = 1'b0;
                    end else if (!rd_present) begin
                        xl_d.rsp_v = 1'b1;
                        xl_d.paddr = '0;
                        xl_d.fault = 1'b1;
                        xl_d.miss  = 1'b0;
                    end else begin
                        xl_d.st    = ST_WALK;
                        xl_d.mreq  = 1'b1;
                        xl_d.maddr = {rd_page, {PAD_W{1'b0}}, lk_off, 2'b00};
                        xl_d.tag   = lk_tag;
                        xl_d.lo    = req_addr[PG_SH-1:0];
                    end
                end
            end
            ST_WALK: begin
                if (mem_rsp_valid) begin
                    xl_d.st    = ST_IDLE;
                    xl_d.mreq  = 1'b0;
                    xl_d.rsp_v = 1'b1;
                    xl_d.miss  = 1'b0;
                    if (mem_rsp_data[0]) begin
                        xl_d.paddr = {mem_rsp_data[ADDR_W-1:PG_SH], xl_q.lo};
                        xl_d.fault = 1'b0;
                        ins_en     = 1'b1;
                    end else begin
                        xl_d.paddr = '0;
                        xl_d.fault = 1'b1;
                    end
                end
            end
            default: xl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) xl_q <= '0;
        else        xl_q <= xl_d;
    end

    assign req_ready     = (xl_q.st == ST_IDLE);
    assign rsp_valid     = xl_q.rsp_v;
    assign rsp_paddr     = xl_q.paddr;
    assign rsp_fault     = xl_q.fault;
    assign rsp_miss      = xl_q.miss;
    assign mem_req_valid = xl_q.mreq;
    assign mem_addr      = xl_q.maddr;

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_addr))); // R4

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R4

    AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> (rsp_paddr == $past(req_addr))); // R7

    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && !rsp_miss)); // R5
endmodule

// File: tb/tb_aperture_xlate.sv
`timescale 1ns/1ps
module tb_aperture_xlate;
    import ax_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] ap_base = 32'h4000_0000;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready, rsp_valid, rsp_fault, rsp_miss, mem_req_valid;
    logic [31:0] rsp_paddr, mem_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    int total = 0;
    int bad = 0;
    int mem_reads = 0;
    int hold_err = 0;
    logic [31:0] last_maddr = '0;

    bit          dp [64];
    logic [11:0] dg [64];
    int          slots = 64;

    always #4 clk = ~clk;

    aperture_xlate dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ap_base(ap_base), .req_valid(req_valid),
        .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_miss(rsp_miss),
        .mem_req_valid(mem_req_valid), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    // second-level contents: valid when entry-offset bit 4 is 0
    function automatic logic [31:0] l2_word(input logic [31:0] a);
        logic [19:0] ppn;
        ppn = {a[27:20], a[13:2]} ^ 20'h5A5A5;
        return {ppn, 11'h000, ~a[6]};
    endfunction

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic dir_load(input int slot, input logic [11:0] pg, input bit pres,
                            input logic [4:0] junk);
        cfg_write(OFF_DIR, {pg, 8'h00, junk[4:2], pres, junk[1:0], 6'(slot)});
        dp[slot] = pres;
        dg[slot] = pg;
    endtask

    task automatic model(input logic [31:0] a, output logic [31:0] pa, output bit f,
                         output bit m, output logic [31:0] ma);
        logic [9:0]  d;
        logic [31:0] w;
        d  = a[31:22] - ap_base[31:22];
        pa = '0; f = 1'b0; m = 1'b0; ma = '0;
        if (int'(d) >= slots) begin
            m = 1'b1; pa = a;
        end else if (!dp[d[5:0]]) begin
            f = 1'b1;
        end else begin
            ma = {dg[d[5:0]], 8'h00, a[21:12], 2'b00};
            w  = l2_word(ma);
            if (w[0]) pa = {w[31:12], a[11:0]};
            else      f = 1'b1;
        end
    endtask

    task automatic xlate(input logic [31:0] a, output logic [31:0] pa, output bit f,
                         output bit m, output int cyc, output int rd);
        int r0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; r0 = mem_reads;
        @(negedge clk);
        req_valid = 1'b0; cyc = 1;
        while (!rsp_valid && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        pa = rsp_paddr; f = rsp_fault; m = rsp_miss; rd = mem_reads - r0;
    endtask

    // walk=1: expects exactly one memory read; walk=0: one-cycle answer, no read
    task automatic run_vec(input logic [31:0] a, input bit walk, input string tag);
        logic [31:0] pa, epa, ema;
        bit f, m, ef, em;
        int cyc, rd;
        model(a, epa, ef, em, ema);
        xlate(a, pa, f, m, cyc, rd);
        check(cyc < 40, tag, "response seen", 32'(cyc), 32'd1);
        check(pa == epa, tag, "paddr", pa, epa);
        check(f == ef && m == em, tag, "fault/miss", {30'd0, f, m}, {30'd0, ef, em});
        if (walk) begin
            check(rd == 1, tag, "memory reads", 32'(rd), 32'd1);
            check(last_maddr == ema, "R3", "read address", last_maddr, ema);
        end else begin
            check(rd == 0, tag, "memory reads", 32'(rd), 32'd0);
            check(cyc == 1, tag, "latency", 32'(cyc), 32'd1);
        end
    endtask

    localparam int NV = 10;
    localparam logic [31:0] VA [NV] = '{
        32'h4000_0123, 32'h4000_0FFF, 32'h4041_5008, 32'h4040_3ABC, 32'h4080_0000,
        32'h4140_F010, 32'h3FC0_0000, 32'h4FC0_1000, 32'h5000_0000, 32'h4000_0456
    };
    localparam bit VW [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam string VT [NV] = '{"R4", "R8", "R5", "R4", "R6", "R4", "R7", "R4", "R7", "R8"};

    initial begin : mem_model
        int wcnt;
        logic [31:0] first;
        mem_rsp_valid = 1'b0; mem_rsp_data = '0; wcnt = 0; first = '0;
        forever begin
            @(negedge clk);
            if (mem_rsp_valid) begin
                mem_rsp_valid = 1'b0;
                wcnt = 0;
            end else if (mem_req_valid) begin
                if (wcnt == 0) first = mem_addr;
                else if (mem_addr != first) hold_err++;
                if (wcnt == 2) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = l2_word(mem_addr);
                    mem_reads++;
                    last_maddr = mem_addr;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 64; i++) begin dp[i] = 1'b0; dg[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(req_ready == 1'b1, "R1", "req_ready", 32'(req_ready), 32'd1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid", 32'(rsp_valid), 32'd0);
        check(mem_req_valid == 1'b0, "R1", "mem_req_valid", 32'(mem_req_valid), 32'd0);
        run_vec(32'h4000_0000, 1'b0, "R1");

        // R2: directory loads, junk in ignored fields on slot 1
        dir_load(0,  12'h123, 1'b1, 5'b00000);
        dir_load(1,  12'h456, 1'b1, 5'b10111);
        dir_load(5,  12'h7AB, 1'b1, 5'b00000);
        dir_load(63, 12'h0FE, 1'b1, 5'b11111);

        for (int i = 0; i < NV; i++) run_vec(VA[i], VW[i], VT[i]);

        // R9: cache holds four pages, ptr back at the oldest
        run_vec(32'h4000_1000, 1'b1, "R9");
        run_vec(32'h4040_3000, 1'b0, "R9");
        run_vec(32'h4000_0000, 1'b1, "R9");
        run_vec(32'h4140_F000, 1'b0, "R9");

        // R10: control register edge flush
        cfg_write(OFF_CTRL, 32'h2280);
        run_vec(32'h4140_F000, 1'b1, "R10");
        cfg_write(OFF_CTRL, 32'h2280);
        run_vec(32'h4140_F000, 1'b0, "R10");
        cfg_write(OFF_CTRL, 32'h2200);
        run_vec(32'h4140_F000, 1'b0, "R10");
        cfg_write(OFF_CTRL, 32'h2280);
        run_vec(32'h4140_F000, 1'b1, "R10");

        // R11: unrelated directory write flushes
        dir_load(9, 12'h321, 1'b1, 5'b00000);
        run_vec(32'h4140_F000, 1'b1, "R11");
        // R2: clearing present makes slot 5 absent
        dir_load(5, 12'h000, 1'b0, 5'b00000);
        run_vec(32'h4140_F000, 1'b0, "R2");
        // R5: faults are not cached
        run_vec(32'h4041_5008, 1'b1, "R5");
        run_vec(32'h4041_5008, 1'b1, "R5");

        // R7: aperture sizes
        cfg_write(OFF_SIZE, 32'd56); slots = 8;
        run_vec(32'h4200_0000, 1'b0, "R7");
        run_vec(32'h41C0_0000, 1'b0, "R7");
        cfg_write(OFF_SIZE, 32'd48); slots = 16;
        run_vec(32'h4200_0000, 1'b0, "R7");
        run_vec(32'h4400_0000, 1'b0, "R7");
        cfg_write(OFF_SIZE, 32'd32); slots = 32;
        run_vec(32'h47C0_0000, 1'b0, "R7");
        run_vec(32'h4800_0000, 1'b0, "R7");
        cfg_write(OFF_SIZE, 32'd0); slots = 64;
        run_vec(32'h4FC0_1000, 1'b1, "R7");
        run_vec(32'h5000_0000, 1'b0, "R7");

        check(hold_err == 0, "R4", "request held stable", 32'(hold_err), 32'd0);
        summary();
        $finish;
    end
endmodule